// File: doc/BRIEF.md
# Oversampled Manchester II Word Decoder

This block turns one serial bus word, seen as a pair of digital receive lines, into a 16-bit value. A sample strobe at 25 MHz gives 25 samples per 1 Mbit/s bit time. The decoder waits for activity on the line. It then measures the three-bit-time sync pattern to learn the word type. It recovers sixteen data bits and an odd parity bit from the mid-bit transitions. At the end it reports either a clean word or a single error code. One instance is placed per bus, so a dual-bus terminal uses two copies.

The receive pair is idle when both lines carry the same value. Otherwise the line level is the value of `rx_p`. Every decode fault ends the word at once. After a fault the decoder waits for an idle sample before it looks for a new sync. A clean word lets the decoder accept another sync on the very next sample, so words sent back to back are decoded.

While a word is being sent, the loopback path can be enabled. The word the encoder meant to send is presented on `lb_word`/`lb_cmd`. The decoded result, or any decode error, is compared with it, and a mismatch raises a fault pulse.

Top module: `mdec_word_decoder`

## Requirements
- R1: After reset `word_valid`, `err_valid` and `lb_fault` are low, and `err_code` and `word_data` are zero.
- R2: A sync whose first level is high (command/status type) sets `word_cmd` to 1, and a low-first sync sets it to 0. The first sync level must change after 37 samples, within ±3 samples (indices 34..40). Otherwise the word ends with `err_code` 1 (sync error).
- R3: Sixteen data bits follow the sync, most significant bit first. A 1 is high in its first half and low in its second half, and a 0 is the inverse. A clean word gives a `word_valid` pulse of one clock cycle, with `err_code` 0.
- R4: A seventeenth bit gives odd parity over all 17 bits. If the parity check fails, the word ends with `err_code` 5.
- R5: The mid-bit transition is nominal at sample offset 12 of a bit. A mid-bit transition at an offset outside 9..15 gives `err_code` 3 (skew). Transitions within that range are accepted.
- R6: A bit window with no mid-bit transition gives `err_code` 2 (invalid waveform). A second transition inside the mid-bit region (offsets 4..21) also gives `err_code` 2.
- R7: An idle sample before all 17 bits are complete ends the word with `err_code` 4 (bit count).
- R8: Transitions at bit offsets 0..3 and 22..24 are treated as boundary jitter and do not affect the decoded word.
- R9: When `lb_en` is high, `lb_fault` pulses with the completion pulse if any of these holds: the word ended in error, the decoded data differs from `lb_word`, or the word type differs from `lb_cmd`. When `lb_en` is low, `lb_fault` stays low.
- R10: After an error the decoder resumes once the line is idle. A second word that starts on the sample right after a clean word's parity bit is also decoded.
- R11: The receive lines are read only in cycles where `smp_en` is high. Changes between strobes have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | 25 MHz sample strobe |
| rx_p | input | 1 | Receive line, true side |
| rx_n | input | 1 | Receive line, complement side |
| lb_en | input | 1 | Loopback compare enable |
| lb_word | input | 16 | Word the encoder intends to send |
| lb_cmd | input | 1 | Intended word type (1 = command/status) |
| word_valid | output | 1 | One-cycle pulse: clean word decoded |
| word_data | output | 16 | Last decoded data word |
| word_cmd | output | 1 | Type of last decoded word |
| err_valid | output | 1 | One-cycle pulse: word ended in error |
| err_code | output | 3 | 0 none, 1 sync, 2 waveform, 3 skew, 4 bit count, 5 parity |
| lb_fault | output | 1 | Loopback mismatch pulse |

## Verification
The in-line properties check a few things on every cycle: completion pulses are single-cycle and never coincide, they follow a real sample, skew and bit-count errors come only from the data phase, sync errors come only from the sync phase, and the registered sample holds between strobes. The correctness of the decoded values and the tolerance windows can be shown only by the bench scenarios. These cover the exact accepted and rejected sync lengths, mid-bit positions on both edges of the skew window, boundary jitter, truncated and parity-corrupted words, back-to-back words and each loopback mismatch type.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_SYNC   = 3'd1,
        ERR_MANCH  = 3'd2,
        ERR_SKEW   = 3'd3,
        ERR_COUNT  = 3'd4,
        ERR_PARITY = 3'd5
    } mdec_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC_A,
        ST_SYNC_B,
        ST_BITS,
        ST_DRAIN
    } mdec_state_e;

    typedef struct packed {
        logic idle;
        logic lvl;
    } mdec_smp_t;

    // true when v lies within c +/- t
    function automatic logic near(input int v, input int c, input int t);
        return (v >= c - t) && (v <= c + t);
    endfunction

endpackage

// File: rtl/mdec_sampler.sv
module mdec_sampler
    import mdec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      smp_en,
    input  logic      rx_p,
    input  logic      rx_n,
    output logic      s_vld,
    output mdec_smp_t smp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_vld <= 1'b0;
            smp_q <= '{idle: 1'b1, lvl: 1'b0};
        end else begin
            s_vld <= smp_en;
            if (smp_en) begin
                smp_q <= '{idle: (rx_p == rx_n), lvl: rx_p};
            end
        end
    end

    // R11: line state only moves on a strobe
    a_r11_hold_between: assert property (@(posedge clk) disable iff (rst)
        !s_vld |-> $stable(smp_q));

endmodule

// File: rtl/mdec_word_fsm.sv
module mdec_word_fsm
    import mdec_pkg::*;
#(
    parameter int SPB = 25,
    parameter int TOL = 3,
    parameter int DW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            s_vld,
    input  mdec_smp_t       smp,
    output logic            done_ok,
    output logic            done_err,
    output logic [DW-1:0]   data_q,
    output logic            cmd_q,
    output mdec_err_e       code_q
);

    localparam int HALF     = SPB / 2;
    localparam int SYNC_A   = SPB + HALF;
    localparam int SYNC_END = 3 * SPB;
    localparam int NBITS    = DW + 1;
    localparam int MID_LO   = TOL + 1;
    localparam int MID_HI   = SPB - 1 - TOL;
    localparam int CW       = $clog2(SYNC_END + 1);
    localparam int OW       = $clog2(SPB);
    localparam int BW       = $clog2(NBITS + 1);

    mdec_state_e      st_q, st_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [OW-1:0]    off_q, off_d;
    logic [BW-1:0]    bidx_q, bidx_d;
    logic [NBITS-1:0] sh_q, sh_d;
    logic             mid_q, mid_d;
    logic             pol_q, pol_d;
    logic             prev_q;
    logic             edge_c;
    logic             hit_err, hit_done;
    mdec_err_e        hit_code;

    assign edge_c = (smp.lvl != prev_q);

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        off_d    = off_q;
        bidx_d   = bidx_q;
        sh_d     = sh_q;
        mid_d    = mid_q;
        pol_d    = pol_q;
        hit_err  = 1'b0;
        hit_done = 1'b0;
        hit_code = ERR_NONE;
        if (s_vld) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!smp.idle) begin
                        pol_d = smp.lvl;
                        cnt_d = CW'(1);
                        st_d  = ST_SYNC_A;
                    end
                end
                ST_SYNC_A: begin
                    cnt_d = cnt_q + CW'(1);
                    if (smp.idle) begin
                        hit_err  = 1'b1;
                        hit_code = ERR_SYNC;
                    end else if (edge_c) begin
                        if (!near(int'(cnt_q), SYNC_A, TOL)) begin
                            hit_err  = 1'b1;
                            hit_code = ERR_SYNC;
                        end else begin
                            st_d = ST_SYNC_B;
                        end
                    end else if (int'(cnt_q) >= SYNC_A + TOL) begin
                        hit_err  = 1'b1;
                        hit_code = ERR_SYNC;
                    end
                end
                ST_SYNC_B: begin
                    cnt_d = cnt_q + CW'(1);
                    if (smp.idle || (edge_c && int'(cnt_q) < SYNC_END - TOL)) begin
                        hit_err  = 1'b1;
                        hit_code = ERR_SYNC;
                    end else if (int'(cnt_q) == SYNC_END - 1) begin
                        st_d   = ST_BITS;
                        off_d  = '0;
                        bidx_d = '0;
                        mid_d  = 1'b0;
                    end
                end
                ST_BITS: begin
                    off_d = off_q + OW'(1);
                    if (smp.idle) begin
                        hit_err  = 1'b1;
                        hit_code = ERR_COUNT;
                    end else begin
                        if (edge_c && int'(off_q) >= MID_LO && int'(off_q) <= MID_HI) begin
                            if (mid_q) begin
                                hit_err  = 1'b1;
                                hit_code = ERR_MANCH;
                            end else if (!near(int'(off_q), HALF, TOL)) begin
                                hit_err  = 1'b1;
                                hit_code = ERR_SKEW;
                            end else begin
                                mid_d = 1'b1;
                                sh_d  = {sh_q[NBITS-2:0], ~smp.lvl};
                            end
                        end
                        if (!hit_err && int'(off_q) == SPB - 1) begin
                            if (!mid_q) begin
                                hit_err  = 1'b1;
                                hit_code = ERR_MANCH;
                            end else if (int'(bidx_q) == NBITS - 1) begin
                                if (^sh_q) begin
                                    hit_done = 1'b1;
                                end else begin
                                    hit_err  = 1'b1;
                                    hit_code = ERR_PARITY;
                                end
                            end else begin
                                bidx_d = bidx_q + BW'(1);
                                off_d  = '0;
                                mid_d  = 1'b0;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (smp.idle) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
            if (hit_err)  st_d = smp.idle ? ST_IDLE : ST_DRAIN;
            if (hit_done) st_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            off_q    <= '0;
            bidx_q   <= '0;
            sh_q     <= '0;
            mid_q    <= 1'b0;
            pol_q    <= 1'b0;
            prev_q   <= 1'b0;
            done_ok  <= 1'b0;
            done_err <= 1'b0;
            data_q   <= '0;
            cmd_q    <= 1'b0;
            code_q   <= ERR_NONE;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            off_q    <= off_d;
            bidx_q   <= bidx_d;
            sh_q     <= sh_d;
            mid_q    <= mid_d;
            pol_q    <= pol_d;
            done_ok  <= hit_done;
            done_err <= hit_err;
            if (s_vld) prev_q <= smp.lvl;
            if (hit_done) begin
                data_q <= sh_q[NBITS-1:1];
                cmd_q  <= pol_q;
                code_q <= ERR_NONE;
            end else if (hit_err) begin
                code_q <= hit_code;
            end
        end
    end

    // R3: a clean word is reported for exactly one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_ok |=> !done_ok);

    // R11: completions only follow a strobed sample
    a_r11_after_sample: assert property (@(posedge clk) disable iff (rst)
        (done_ok || done_err) |-> $past(s_vld));

    // R5: skew is judged only while bits are being timed
    a_r5_skew_in_bits: assert property (@(posedge clk) disable iff (rst)
        (done_err && code_q == ERR_SKEW) |-> $past(st_q) == ST_BITS);

    // R7: a short word is only detected during the data phase
    a_r7_count_in_bits: assert property (@(posedge clk) disable iff (rst)
        (done_err && code_q == ERR_COUNT) |-> $past(st_q) == ST_BITS);

    // R2: sync faults come from the sync phase
    a_r2_sync_src: assert property (@(posedge clk) disable iff (rst)
        (done_err && code_q == ERR_SYNC) |-> ($past(st_q) == ST_SYNC_A || $past(st_q) == ST_SYNC_B));

    // R4: the bit index never runs past the parity bit
    a_r4_bit_bound: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_BITS |-> int'(bidx_q) < NBITS);

endmodule

// File: rtl/mdec_lb_check.sv
module mdec_lb_check #(
    parameter int DW = 16
) (
    input  logic          done_ok,
    input  logic          done_err,
    input  logic [DW-1:0] data,
    input  logic          cmd,
    input  logic          lb_en,
    input  logic [DW-1:0] lb_word,
    input  logic          lb_cmd,
    output logic          fault
);

    logic mismatch;

    assign mismatch = (data != lb_word) || (cmd != lb_cmd);
    assign fault    = lb_en && (done_err || (done_ok && mismatch));

endmodule

// File: rtl/mdec_word_decoder.sv
module mdec_word_decoder
    import mdec_pkg::*;
#(
    parameter int SPB = 25,
    parameter int TOL = 3,
    parameter int DW  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_en,
    input  logic          rx_p,
    input  logic          rx_n,
    input  logic          lb_en,
    input  logic [DW-1:0] lb_word,
    input  logic          lb_cmd,
    output logic          word_valid,
    output logic [DW-1:0] word_data,
    output logic          word_cmd,
    output logic          err_valid,
    output logic [2:0]    err_code,
    output logic          lb_fault
);

    logic      s_vld;
    mdec_smp_t smp;
    mdec_err_e code;

    mdec_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .smp_en (smp_en),
        .rx_p   (rx_p),
        .rx_n   (rx_n),
        .s_vld  (s_vld),
        .smp_q  (smp)
    );

    mdec_word_fsm #(.SPB(SPB), .TOL(TOL), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .s_vld    (s_vld),
        .smp      (smp),
        .done_ok  (word_valid),
        .done_err (err_valid),
        .data_q   (word_data),
        .cmd_q    (word_cmd),
        .code_q   (code)
    );

    assign err_code = code;

    mdec_lb_check #(.DW(DW)) u_lb (
        .done_ok  (word_valid),
        .done_err (err_valid),
        .data     (word_data),
        .cmd      (word_cmd),
        .lb_en    (lb_en),
        .lb_word  (lb_word),
        .lb_cmd   (lb_cmd),
        .fault    (lb_fault)
    );

    // R10: a word ends in exactly one way
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(word_valid && err_valid));

    // R9: the loopback fault only rides on a completion
    a_r9_fault_at_end: assert property (@(posedge clk) disable iff (rst)
        lb_fault |-> (word_valid || err_valid));

endmodule

// File: tb/mdec_word_decoder_tb_top.sv
module mdec_word_decoder_tb_top;

    localparam int SPB  = 25;
    localparam int HALF = 12;
    localparam int SEND = 75;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b0;
    logic        rx_p = 1'b0, rx_n = 1'b0;
    logic        lb_en = 1'b0, lb_cmd = 1'b0;
    logic [15:0] lb_word = '0;
    logic        word_valid, word_cmd, err_valid, lb_fault;
    logic [15:0] word_data;
    logic [2:0]  err_code;

    mdec_word_decoder dut_i (
        .clk(clk), .rst(rst), .smp_en(smp_en), .rx_p(rx_p), .rx_n(rx_n),
        .lb_en(lb_en), .lb_word(lb_word), .lb_cmd(lb_cmd),
        .word_valid(word_valid), .word_data(word_data), .word_cmd(word_cmd),
        .err_valid(err_valid), .err_code(err_code), .lb_fault(lb_fault)
    );

    always #2 clk = ~clk;

    int pc = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        pc     <= (pc == 9) ? 0 : pc + 1;
        smp_en <= (pc == 9);
    end

    typedef struct {
        bit        is_err;
        bit [2:0]  code;
        bit [15:0] data;
        bit        cmd;
        bit        lbf;
        string     tag;
    } exp_t;

    exp_t     exq[$];
    bit [1:0] wq[$];
    int       checks = 0;
    int       errors = 0;
    bit       glitch = 0;
    bit       done_all = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_lvl(input int idx, input bit l);
        wq[idx] = {l, ~l};
    endtask

    task automatic add_word(input bit cmd, input bit [15:0] d, input bit pflip, input int sa);
        bit [16:0] bits;
        bits = {d, (~(^d)) ^ pflip};
        for (int i = 0; i < sa; i++)        wq.push_back({cmd, ~cmd});
        for (int i = sa; i < SEND; i++)     wq.push_back({~cmd, cmd});
        for (int k = 16; k >= 0; k--) begin
            for (int o = 0; o < HALF; o++)  wq.push_back({bits[k], ~bits[k]});
            for (int o = HALF; o < SPB; o++) wq.push_back({~bits[k], bits[k]});
        end
    endtask

    function automatic int at(input int k, input int o);
        return SEND + SPB * k + o;
    endfunction

    function automatic bit bitv(input bit [15:0] d, input int k);
        return d[15 - k];
    endfunction

    task automatic put_sample(input bit [1:0] v);
        @(negedge clk);
        while (!smp_en) @(negedge clk);
        {rx_p, rx_n} = v;
        if (glitch) begin
            @(negedge clk);
            rx_p = ~rx_p;
        end
    endtask

    task automatic drive();
        while (wq.size() > 0) put_sample(wq.pop_front());
        for (int i = 0; i < 10; i++) put_sample(2'b00);
    endtask

    task automatic exp_ok(input bit cmd, input bit [15:0] d, input bit lbf, input string tag);
        exp_t e;
        e.is_err = 0; e.code = 0; e.data = d; e.cmd = cmd; e.lbf = lbf; e.tag = tag;
        exq.push_back(e);
    endtask

    task automatic exp_err(input bit [2:0] code, input bit lbf, input string tag);
        exp_t e;
        e.is_err = 1; e.code = code; e.data = '0; e.cmd = 0; e.lbf = lbf; e.tag = tag;
        exq.push_back(e);
    endtask

    // monitor / scoreboard
    exp_t me;
    always @(negedge clk) begin
        if (!rst && (word_valid || err_valid)) begin
            if (exq.size() == 0) begin
                chk(0, "R3", "unexpected completion", int'(err_code), 0);
            end else begin
                me = exq.pop_front();
                chk(err_valid == me.is_err, me.tag, "outcome err_valid", int'(err_valid), int'(me.is_err));
                chk(err_code == me.code, me.tag, "err_code", int'(err_code), int'(me.code));
                if (!me.is_err) begin
                    chk(word_data == me.data, me.tag, "word_data", int'(word_data), int'(me.data));
                    chk(word_cmd == me.cmd, me.tag, "word_cmd", int'(word_cmd), int'(me.cmd));
                end
                chk(lb_fault == me.lbf, me.tag, "lb_fault", int'(lb_fault), int'(me.lbf));
            end
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(word_valid == 0, "R1", "word_valid", int'(word_valid), 0);
        chk(err_valid == 0, "R1", "err_valid", int'(err_valid), 0);
        chk(err_code == 0, "R1", "err_code", int'(err_code), 0);
        chk(word_data == 0, "R1", "word_data", int'(word_data), 0);
        chk(lb_fault == 0, "R1", "lb_fault", int'(lb_fault), 0);
        for (int i = 0; i < 5; i++) put_sample(2'b00);

        // R2 R3 both word types, varied data
        exp_ok(1, 16'h8001, 0, "R2"); add_word(1, 16'h8001, 0, 37); drive();
        exp_ok(0, 16'hA5C3, 0, "R3"); add_word(0, 16'hA5C3, 0, 37); drive();
        exp_ok(1, 16'hFFFF, 0, "R3"); add_word(1, 16'hFFFF, 0, 37); drive();
        exp_ok(0, 16'h0000, 0, "R3"); add_word(0, 16'h0000, 0, 37); drive();

        // R2 sync timing edges
        exp_ok(1, 16'h1234, 0, "R2"); add_word(1, 16'h1234, 0, 34); drive();
        exp_ok(0, 16'h4321, 0, "R2"); add_word(0, 16'h4321, 0, 40); drive();
        exp_err(3'd1, 0, "R2"); add_word(1, 16'h1234, 0, 33); drive();
        exp_err(3'd1, 0, "R2"); add_word(0, 16'h1234, 0, 41); drive();

        // R4 parity
        exp_err(3'd5, 0, "R4"); add_word(1, 16'h0F0F, 1, 37); drive();

        // R5 accepted skew at both limits
        add_word(0, 16'h3C5A, 0, 37);
        for (int o = 12; o < 15; o++) set_lvl(at(3, o), bitv(16'h3C5A, 3));
        for (int o = 9; o < 12; o++)  set_lvl(at(5, o), ~bitv(16'h3C5A, 5));
        exp_ok(0, 16'h3C5A, 0, "R5"); drive();
        // R5 late mid transition
        add_word(0, 16'h3C5A, 0, 37);
        for (int o = 12; o < 16; o++) set_lvl(at(4, o), bitv(16'h3C5A, 4));
        exp_err(3'd3, 0, "R5"); drive();
        // R5 early mid transition
        add_word(1, 16'h3C5A, 0, 37);
        for (int o = 8; o < 12; o++) set_lvl(at(6, o), ~bitv(16'h3C5A, 6));
        exp_err(3'd3, 0, "R5"); drive();

        // R6 missing mid transition
        add_word(1, 16'h00FF, 0, 37);
        for (int o = 12; o < 25; o++) set_lvl(at(7, o), bitv(16'h00FF, 7));
        exp_err(3'd2, 0, "R6"); drive();
        // R6 double transition in mid region
        add_word(0, 16'h00FF, 0, 37);
        set_lvl(at(2, 14), bitv(16'h00FF, 2));
        set_lvl(at(2, 15), bitv(16'h00FF, 2));
        exp_err(3'd2, 0, "R6"); drive();

        // R7 truncated word
        add_word(1, 16'hBEEF, 0, 37);
        while (wq.size() > at(10, 0)) void'(wq.pop_back());
        exp_err(3'd4, 0, "R7"); drive();

        // R8 boundary jitter ignored
        add_word(1, 16'hFFFF, 0, 37);
        for (int o = 0; o < 3; o++)   set_lvl(at(6, o), 1'b0);
        for (int o = 22; o < 25; o++) set_lvl(at(9, o), 1'b1);
        exp_ok(1, 16'hFFFF, 0, "R8"); drive();

        // R9 loopback
        lb_en = 1; lb_word = 16'h5A5A; lb_cmd = 0;
        exp_ok(0, 16'h5A5A, 0, "R9"); add_word(0, 16'h5A5A, 0, 37); drive();
        exp_ok(0, 16'h5A5B, 1, "R9"); add_word(0, 16'h5A5B, 0, 37); drive();
        exp_ok(1, 16'h5A5A, 1, "R9"); add_word(1, 16'h5A5A, 0, 37); drive();
        exp_err(3'd5, 1, "R9"); add_word(0, 16'h5A5A, 1, 37); drive();
        lb_en = 0;
        exp_ok(1, 16'h0001, 0, "R9"); add_word(1, 16'h0001, 0, 37); drive();

        // R10 back-to-back words
        add_word(1, 16'hC001, 0, 37);
        add_word(0, 16'h7E81, 0, 37);
        exp_ok(1, 16'hC001, 0, "R10");
        exp_ok(0, 16'h7E81, 0, "R10");
        drive();

        // R11 glitches between strobes
        glitch = 1;
        exp_ok(0, 16'h9669, 0, "R11"); add_word(0, 16'h9669, 0, 37); drive();
        glitch = 0;

        repeat (20) @(negedge clk);
        chk(exq.size() == 0, "R10", "pending expected items", exq.size(), 0);
        done_all = 1;
    end

    initial begin
        while (!done_all && cyc < 195000) @(posedge clk);
        if (!done_all) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule